// File: doc/BRIEF.md
# Precise-Interrupt Reorder Buffer

This block is a circular in-order retirement queue. It sits between instruction issue and the architectural register file. Execution units may finish in any order, but a result reaches the register file only when its instruction is the oldest one still in flight. Issue logic claims a slot at the tail and gets back a tag. A functional unit later returns the same tag, together with the result and a fault flag. The oldest slot retires from the head. A slot stores the destination register, the result, a completion bit, a fault bit, a store marker and the program counter of the instruction.

A store takes a slot so that it keeps its place in program order, but it never writes a register. When the oldest slot completes with a fault, nothing more retires. That slot and every younger slot are dropped, and one cycle later a single-cycle interrupt pulse carries the faulting instruction's program counter as the resume point. A combinational lookup port lets issue logic read a pending value for a source register before that value is committed.

Top module: `prec_rob`

## Requirements
- R1: Each accepted issue (`iss_valid` high while `iss_ready` is high) fills the slot whose number is shown on `iss_tag`. Tags count up by one per accepted issue, wrap modulo DEPTH, and restart at 0 after reset or a flush. `iss_ready` is low whenever DEPTH slots are occupied, even in a cycle in which the head retires.
- R2: Issue and retirement can happen in the same cycle, and occupancy then stays the same. Pointers wrap, so the buffer can be reused without limit.
- R3: A result with `res_valid` high completes the occupied slot named by `res_tag`, recording `res_data` and `res_exc`. A result aimed at an unoccupied slot has no effect.
- R4: The head retires only after it has completed. Slots retire strictly in issue order, whatever order their results arrived in. Each non-store slot without a fault gives exactly one cycle with `cm_we` high, carrying its destination on `cm_dst` and its value on `cm_data`.
- R5: A store slot (`iss_store` high at issue) retires in order once its result arrives, but never raises `cm_we`.
- R6: While the head has completed with a fault, `cm_we` and `iss_ready` are low. In the next cycle `irq_valid` is high for exactly one cycle, `irq_pc` holds that slot's program counter, and the buffer is empty. The faulting slot and every younger slot are discarded without writing.
- R7: For `byp_reg`, the lookup picks the youngest occupied non-store slot with that destination. `byp_hit` reports whether such a slot exists. `byp_ready` is high only if that slot has its result, and `byp_data` then holds that result. The register file is still written only through retirement.
- R8: After reset the buffer is empty: `iss_ready` is 1, `iss_tag` is 0, and `cm_we`, `irq_valid` and `byp_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_store | input | 1 | Issued instruction is a store placeholder |
| iss_dst | input | AW | Destination register of the issued instruction |
| iss_pc | input | PW | Program counter of the issued instruction |
| iss_ready | output | 1 | Slot available and no fault pending |
| iss_tag | output | $clog2(DEPTH) | Tag given to the issue in this cycle |
| res_valid | input | 1 | Result return |
| res_tag | input | $clog2(DEPTH) | Slot the result belongs to |
| res_data | input | DW | Result value |
| res_exc | input | 1 | Result carries a fault |
| byp_reg | input | AW | Source register looked up |
| byp_hit | output | 1 | A pending slot writes that register |
| byp_ready | output | 1 | The matching slot has its result |
| byp_data | output | DW | Value of the matching slot |
| cm_we | output | 1 | Register file write strobe |
| cm_dst | output | AW | Register file write address |
| cm_data | output | DW | Register file write data |
| irq_valid | output | 1 | One-cycle interrupt pulse after a flush |
| irq_pc | output | PW | Resume program counter |

## Verification
The bench builds the block with DEPTH=4 and 16-bit values and program counters. With only four slots, a full buffer, the stall that holds even while the head retires, and tag wrap-around all occur within a few issues. The same small depth lets one scenario cover a fault behind a completed older slot and ahead of completed younger slots, together with stale results aimed at slots that were flushed.

// File: rtl/prec_rob.sv
module prec_rob #(
  parameter int DEPTH = 8,
  parameter int AW    = 5,
  parameter int DW    = 32,
  parameter int PW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iss_valid,
  input  logic                     iss_store,
  input  logic [AW-1:0]            iss_dst,
  input  logic [PW-1:0]            iss_pc,
  output logic                     iss_ready,
  output logic [$clog2(DEPTH)-1:0] iss_tag,
  input  logic                     res_valid,
  input  logic [$clog2(DEPTH)-1:0] res_tag,
  input  logic [DW-1:0]            res_data,
  input  logic                     res_exc,
  input  logic [AW-1:0]            byp_reg,
  output logic                     byp_hit,
  output logic                     byp_ready,
  output logic [DW-1:0]            byp_data,
  output logic                     cm_we,
  output logic [AW-1:0]            cm_dst,
  output logic [DW-1:0]            cm_data,
  output logic                     irq_valid,
  output logic [PW-1:0]            irq_pc
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;

  logic [DEPTH-1:0] busy, done, exc, st;
  logic [AW-1:0]    dst_q [DEPTH];
  logic [DW-1:0]    val_q [DEPTH];
  logic [PW-1:0]    pc_q  [DEPTH];
  logic [IW-1:0]    head, tail;
  logic [CW-1:0]    cnt;

  logic fault_head, retire, full, alloc;

  assign fault_head = busy[head] & done[head] & exc[head];
  assign retire     = busy[head] & done[head] & ~exc[head];
  assign full       = (cnt == CW'(DEPTH));
  assign iss_ready  = ~full & ~fault_head;
  assign alloc      = iss_valid & iss_ready;
  assign iss_tag    = tail;

  assign cm_we   = retire & ~st[head];
  assign cm_dst  = dst_q[head];
  assign cm_data = val_q[head];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= '0;
      done      <= '0;
      exc       <= '0;
      st        <= '0;
      head      <= '0;
      tail      <= '0;
      cnt       <= '0;
      irq_valid <= 1'b0;
      irq_pc    <= '0;
    end else if (fault_head) begin
      busy      <= '0;
      done      <= '0;
      exc       <= '0;
      head      <= '0;
      tail      <= '0;
      cnt       <= '0;
      irq_valid <= 1'b1;
      irq_pc    <= pc_q[head];
    end else begin
      irq_valid <= 1'b0;
      if (res_valid && busy[res_tag]) begin
        done[res_tag] <= 1'b1;
        exc[res_tag]  <= res_exc;
      end
      if (alloc) begin
        busy[tail] <= 1'b1;
        done[tail] <= 1'b0;
        exc[tail]  <= 1'b0;
        st[tail]   <= iss_store;
        tail       <= tail + IW'(1);
      end
      if (retire) begin
        busy[head] <= 1'b0;
        done[head] <= 1'b0;
        head       <= head + IW'(1);
      end
      cnt <= cnt + CW'(alloc) - CW'(retire);
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      dst_q[tail] <= iss_dst;
      pc_q[tail]  <= iss_pc;
    end
    if (res_valid && busy[res_tag] && !fault_head)
      val_q[res_tag] <= res_data;
  end

  logic [IW-1:0] scan;
  always_comb begin
    byp_hit   = 1'b0;
    byp_ready = 1'b0;
    byp_data  = '0;
    scan      = '0;
    for (int i = 0; i < DEPTH; i++) begin
      scan = head + IW'(i);
      if (busy[scan] && !st[scan] && dst_q[scan] == byp_reg) begin
        byp_hit   = 1'b1;
        byp_ready = done[scan];
        byp_data  = val_q[scan];
      end
    end
  end

  a_r1_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  a_r2_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_head |=> cnt == $past(cnt) + CW'($past(alloc)) - CW'($past(retire)));

  a_r3_ignore_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !busy[res_tag]) |=> !done[$past(res_tag)]);

  a_r4_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> head == $past(head) + IW'(1));

  a_r6_flush: assert property (@(posedge clk) disable iff (!rst_n)
    fault_head |=> (irq_valid && cnt == '0 && irq_pc == $past(pc_q[head])));

  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);
endmodule

// File: tb/prec_rob_tb.sv
module prec_rob_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int PW = 16;
  localparam int TW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0, iss_store = 1'b0;
  logic [AW-1:0] iss_dst = '0;
  logic [PW-1:0] iss_pc = '0;
  logic iss_ready;
  logic [TW-1:0] iss_tag;
  logic res_valid = 1'b0, res_exc = 1'b0;
  logic [TW-1:0] res_tag = '0;
  logic [DW-1:0] res_data = '0;
  logic [AW-1:0] byp_reg = '0;
  logic byp_hit, byp_ready;
  logic [DW-1:0] byp_data;
  logic cm_we;
  logic [AW-1:0] cm_dst;
  logic [DW-1:0] cm_data;
  logic irq_valid;
  logic [PW-1:0] irq_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  prec_rob #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_store(iss_store), .iss_dst(iss_dst), .iss_pc(iss_pc),
    .iss_ready(iss_ready), .iss_tag(iss_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data), .res_exc(res_exc),
    .byp_reg(byp_reg), .byp_hit(byp_hit), .byp_ready(byp_ready), .byp_data(byp_data),
    .cm_we(cm_we), .cm_dst(cm_dst), .cm_data(cm_data),
    .irq_valid(irq_valid), .irq_pc(irq_pc));

  int checks = 0;
  int errors = 0;
  int nlog = 0;
  logic [AW-1:0] ldst [32];
  logic [DW-1:0] ldat [32];
  logic [TW-1:0] exp_tag = '0;

  always @(negedge clk) begin
    if (rst_n && cm_we) begin
      if (nlog < 32) begin
        ldst[nlog] = cm_dst;
        ldat[nlog] = cm_data;
      end
      nlog++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_issue(input bit s, input logic [AW-1:0] d, input logic [PW-1:0] p,
                          input bit exp_ok, output logic [TW-1:0] tag);
    @(negedge clk);
    iss_valid = 1'b1; iss_store = s; iss_dst = d; iss_pc = p;
    #1;
    chk(iss_ready == exp_ok, "R1", "iss_ready", iss_ready, exp_ok);
    tag = iss_tag;
    if (exp_ok) begin
      chk(iss_tag == exp_tag, "R1", "iss_tag", iss_tag, exp_tag);
      exp_tag = exp_tag + TW'(1);
    end
    @(posedge clk); #1;
    iss_valid = 1'b0; iss_store = 1'b0;
  endtask

  task automatic send_res(input logic [TW-1:0] t, input logic [DW-1:0] v, input bit e);
    @(negedge clk);
    res_valid = 1'b1; res_tag = t; res_data = v; res_exc = e;
    @(posedge clk); #1;
    res_valid = 1'b0; res_exc = 1'b0;
  endtask

  task automatic expect_log(input int idx, input logic [AW-1:0] d, input logic [DW-1:0] v,
                            input string req);
    chk(ldst[idx] == d, req, "commit dst", ldst[idx], d);
    chk(ldat[idx] == v, req, "commit data", ldat[idx], v);
  endtask

  task automatic t_reset;
    #1;
    chk(iss_ready == 1'b1, "R8", "iss_ready after reset", iss_ready, 1);
    chk(iss_tag == '0, "R8", "iss_tag after reset", iss_tag, 0);
    chk(cm_we == 1'b0, "R8", "cm_we after reset", cm_we, 0);
    chk(irq_valid == 1'b0, "R8", "irq_valid after reset", irq_valid, 0);
    chk(byp_hit == 1'b0, "R8", "byp_hit after reset", byp_hit, 0);
  endtask

  task automatic t_inorder;
    logic [TW-1:0] a, b, c;
    nlog = 0;
    do_issue(0, 5'd1, 16'h100, 1, a);
    do_issue(0, 5'd2, 16'h104, 1, b);
    do_issue(0, 5'd3, 16'h108, 1, c);
    send_res(c, 16'h0c0c, 0);
    send_res(b, 16'h0b0b, 0);
    wait_cycles(3);
    chk(nlog == 0, "R4", "commits before head done", nlog, 0);
    send_res(a, 16'h0a0a, 0);
    wait_cycles(5);
    chk(nlog == 3, "R4", "commit count", nlog, 3);
    expect_log(0, 5'd1, 16'h0a0a, "R4");
    expect_log(1, 5'd2, 16'h0b0b, "R4");
    expect_log(2, 5'd3, 16'h0c0c, "R4");
  endtask

  task automatic t_full_wrap;
    logic [TW-1:0] ta, tb, tc, td, te, tf, tx;
    nlog = 0;
    do_issue(0, 5'd12, 16'h200, 1, ta);
    do_issue(0, 5'd13, 16'h204, 1, tb);
    do_issue(0, 5'd14, 16'h208, 1, tc);
    do_issue(0, 5'd15, 16'h20c, 1, td);
    wait_cycles(1);
    chk(iss_ready == 1'b0, "R1", "ready when full", iss_ready, 0);
    send_res(ta, 16'h0120, 0);
    do_issue(0, 5'd16, 16'h210, 0, tx);
    send_res(tb, 16'h0130, 0);
    do_issue(0, 5'd16, 16'h210, 1, te);
    do_issue(0, 5'd17, 16'h214, 1, tf);
    do_issue(0, 5'd18, 16'h218, 0, tx);
    chk(te == ta, "R2", "wrapped tag", te, ta);
    send_res(tc, 16'h0140, 0);
    send_res(td, 16'h0150, 0);
    send_res(te, 16'h0160, 0);
    send_res(tf, 16'h0170, 0);
    wait_cycles(6);
    chk(nlog == 6, "R2", "commit count", nlog, 6);
    expect_log(0, 5'd12, 16'h0120, "R2");
    expect_log(1, 5'd13, 16'h0130, "R2");
    expect_log(4, 5'd16, 16'h0160, "R2");
    expect_log(5, 5'd17, 16'h0170, "R2");
  endtask

  task automatic t_store;
    logic [TW-1:0] s, n;
    nlog = 0;
    do_issue(1, 5'd7, 16'h300, 1, s);
    do_issue(0, 5'd4, 16'h304, 1, n);
    send_res(n, 16'h0444, 0);
    wait_cycles(3);
    chk(nlog == 0, "R5", "commit behind pending store", nlog, 0);
    send_res(s, 16'h0777, 0);
    wait_cycles(4);
    chk(nlog == 1, "R5", "store writes nothing", nlog, 1);
    expect_log(0, 5'd4, 16'h0444, "R5");
  endtask

  task automatic t_ignore;
    logic [TW-1:0] p, q;
    logic [TW-1:0] idle;
    nlog = 0;
    idle = exp_tag + TW'(1);
    send_res(idle, 16'h0dead, 0);
    do_issue(0, 5'd10, 16'h400, 1, p);
    do_issue(0, 5'd11, 16'h404, 1, q);
    byp_reg = 5'd11;
    wait_cycles(1);
    chk(byp_hit == 1'b1, "R3", "hit on slot that got stale result", byp_hit, 1);
    chk(byp_ready == 1'b0, "R3", "stale result ignored", byp_ready, 0);
    send_res(q, 16'h0b11, 0);
    send_res(p, 16'h0a10, 0);
    wait_cycles(4);
    chk(nlog == 2, "R3", "commit count", nlog, 2);
    expect_log(1, 5'd11, 16'h0b11, "R3");
  endtask

  task automatic t_bypass;
    logic [TW-1:0] x, y, z;
    nlog = 0;
    do_issue(0, 5'd5, 16'h500, 1, x);
    do_issue(0, 5'd5, 16'h504, 1, y);
    do_issue(1, 5'd5, 16'h508, 1, z);
    byp_reg = 5'd5;
    wait_cycles(1);
    chk(byp_hit == 1'b1, "R7", "hit pending", byp_hit, 1);
    chk(byp_ready == 1'b0, "R7", "youngest not ready", byp_ready, 0);
    send_res(x, 16'h0011, 0);
    #1;
    chk(byp_ready == 1'b0, "R7", "older result not chosen", byp_ready, 0);
    send_res(y, 16'h0022, 0);
    #1;
    chk(byp_ready == 1'b1, "R7", "youngest ready", byp_ready, 1);
    chk(byp_data == 16'h0022, "R7", "youngest data", byp_data, 16'h0022);
    byp_reg = 5'd9;
    #1;
    chk(byp_hit == 1'b0, "R7", "no match", byp_hit, 0);
    send_res(z, 16'h0999, 0);
    wait_cycles(4);
    chk(nlog == 2, "R7", "commit count", nlog, 2);
    expect_log(0, 5'd5, 16'h0011, "R7");
    expect_log(1, 5'd5, 16'h0022, "R7");
  endtask

  task automatic t_fault;
    logic [TW-1:0] a, b, c, d;
    nlog = 0;
    do_issue(0, 5'd1, 16'h600, 1, a);
    do_issue(0, 5'd2, 16'h604, 1, b);
    do_issue(0, 5'd3, 16'h608, 1, c);
    do_issue(0, 5'd4, 16'h60c, 1, d);
    send_res(c, 16'h0333, 0);
    send_res(a, 16'h0111, 0);
    send_res(b, 16'h0222, 1);
    @(negedge clk); #1;
    chk(iss_ready == 1'b0, "R6", "ready at faulting head", iss_ready, 0);
    chk(cm_we == 1'b0, "R6", "no write at faulting head", cm_we, 0);
    @(negedge clk); #1;
    chk(irq_valid == 1'b1, "R6", "irq pulse", irq_valid, 1);
    chk(irq_pc == 16'h604, "R6", "irq pc", irq_pc, 16'h604);
    chk(iss_tag == '0, "R6", "tag after flush", iss_tag, 0);
    chk(iss_ready == 1'b1, "R6", "ready after flush", iss_ready, 1);
    exp_tag = '0;
    @(negedge clk); #1;
    chk(irq_valid == 1'b0, "R6", "irq single cycle", irq_valid, 0);
    byp_reg = 5'd3;
    #1;
    chk(byp_hit == 1'b0, "R6", "younger slot discarded", byp_hit, 0);
    send_res(d, 16'h0444, 0);
    wait_cycles(4);
    chk(nlog == 1, "R6", "only older slot committed", nlog, 1);
    expect_log(0, 5'd1, 16'h0111, "R6");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_inorder();
    t_full_wrap();
    t_store();
    t_ignore();
    t_bypass();
    t_fault();
    t_inorder();
    report();
  end
endmodule